// File: doc/BRIEF.md
# Byte-Aligned Nine-Bit Run Detector

This block looks at a 65-bit data word and reports, for each of its eight byte lanes, whether a run of nine identical bits starts at that lane's lowest bit. The nine bits are the lane's own eight bits plus the lowest bit of the lane above it. For lane 7, that borrowed bit is the single extra top bit of the word. The extra bit also picks the polarity to test. When it is 1, the lane is checked for all ones. When it is 0, the lane is checked for all zeros. A match therefore means that all nine bits agree.

A producer presents a word together with a valid strobe. One clock later the block presents an 8-bit flag vector, one bit per lane, together with an output valid strobe. Runs that start anywhere other than a byte boundary are not reported. The block keeps no history from one word to the next.

Top module: `byte_run_detector`

## Requirements
- R1: A synchronous active-high reset clears every output flag and the output valid to 0 on the clock edge where it is sampled, and this takes priority over an input valid on that same edge.
- R2: The output valid is 1 in exactly the cycle after a cycle in which the input valid was 1 (outside reset), and 0 otherwise.
- R3: The flag for lane b (bit b of the flag vector) is 1 when input bits 8b to 8b+7 are all 0 and input bit 8b+8 is 0.
- R4: The flag for lane b is 1 when input bits 8b to 8b+7 are all 1 and input bit 8b+8 is 1.
- R5: The flag for lane b is 0 when the lane bits are all 1 but bit 8b+8 is 0. It is also 0 when the lane bits are all 0 but bit 8b+8 is 1.
- R6: Lane 7 takes its selector from input bit 64, the most significant bit of the word.
- R7: A run of nine or more equal bits that does not start at bit 8b for some lane b raises no flag for any lane whose own nine-bit window is mixed.
- R8: Several flags may assert for one word. An all-zero word and an all-one word each give flags 0xFF, and a word of alternating bits gives 0x00.
- R9: While the input valid is 0, the flag vector keeps the value it last took.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | The word on inData is to be examined |
| inData | input | 65 | Data word; bit 8b+8 is the selector for lane b |
| outValid | output | 1 | Flags below belong to the word accepted one cycle earlier |
| outFlags | output | 8 | One run flag per byte lane, bit b for lane b |

## Verification
Some properties are checked on every clock. After each accepted word, each lane's flag must equal the test "the nine bits starting at 8b are all equal", computed from the previous cycle's input. The output valid must follow the input valid by exactly one cycle, the flags must hold while no word is accepted, and reset must leave everything at zero. Other behaviours only show up in the bench's scenarios. These include the split between the all-ones and all-zeros cases, lane 7 reading the top word bit, unaligned runs that stay silent, and words with several matching lanes. The bench sweeps every nine-bit pattern in every lane against varied background words to cover them.

// File: rtl/run_det_pkg.sv
package run_det_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;   // capture fresh flags this edge
    logic clear;  // force flags to zero this edge
  } runStrobes_t;

endpackage

// File: rtl/run_lane_cmp.sv
module run_lane_cmp #(
  parameter int LANE_BITS = 8
) (
  input  logic [LANE_BITS-1:0] laneBits,
  input  logic                 selBit,
  output logic                 hit
);

  logic allZero;
  logic allOne;

  always_comb begin
    allZero = ~|laneBits;
    allOne  = &laneBits;   // lane bits only, selector excluded
    hit     = selBit ? allOne : allZero;
  end

endmodule

// File: rtl/run_ctrl.sv
module run_ctrl
  import run_det_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output runStrobes_t strobes,
  output logic        outValid
);

  always_comb begin
    strobes.clear = rst;
    strobes.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

endmodule

// File: rtl/run_datapath.sv
module run_datapath
  import run_det_pkg::*;
#(
  parameter int LANE_BITS  = 8,
  parameter int LANE_COUNT = 8,
  localparam int WORD_BITS = LANE_BITS * LANE_COUNT + 1
) (
  input  logic                  clk,
  input  runStrobes_t           strobes,
  input  logic [WORD_BITS-1:0]  inData,
  output logic [LANE_COUNT-1:0] flags
);

  logic [LANE_COUNT-1:0] laneHit;

  for (genvar gLane = 0; gLane < LANE_COUNT; gLane++) begin : gLanes
    run_lane_cmp #(.LANE_BITS(LANE_BITS)) laneCmp_i (
      .laneBits (inData[gLane*LANE_BITS +: LANE_BITS]),
      .selBit   (inData[(gLane+1)*LANE_BITS]),
      .hit      (laneHit[gLane])
    );
  end

  always_ff @(posedge clk) begin
    if (strobes.clear)     flags <= '0;
    else if (strobes.load) flags <= laneHit;
  end

endmodule

// File: rtl/byte_run_detector.sv
module byte_run_detector
  import run_det_pkg::*;
#(
  parameter int LANE_BITS  = 8,
  parameter int LANE_COUNT = 8,
  localparam int WORD_BITS = LANE_BITS * LANE_COUNT + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [WORD_BITS-1:0]  inData,
  output logic                  outValid,
  output logic [LANE_COUNT-1:0] outFlags
);

  runStrobes_t strobes;

  run_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  run_datapath #(
    .LANE_BITS  (LANE_BITS),
    .LANE_COUNT (LANE_COUNT)
  ) dpath_i (
    .clk     (clk),
    .strobes (strobes),
    .inData  (inData),
    .flags   (outFlags)
  );

endmodule

// File: rtl/byte_run_detector_chk.sv
module byte_run_detector_chk #(
  parameter int LANE_BITS  = 8,
  parameter int LANE_COUNT = 8,
  localparam int WORD_BITS = LANE_BITS * LANE_COUNT + 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  inValid,
  input logic [WORD_BITS-1:0]  inData,
  input logic                  outValid,
  input logic [LANE_COUNT-1:0] outFlags
);

  logic rstQ = 1'b0;

  always_ff @(posedge clk) rstQ <= rst;

  always @(negedge clk) begin
    if (rstQ) begin
      AST_RESET_CLEAR: assert (outFlags == '0 && !outValid); // R1
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R2

  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R2

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(outFlags)); // R9

  for (genvar gLane = 0; gLane < LANE_COUNT; gLane++) begin : gLaneChk
    AST_RUN_MATCH: assert property (@(posedge clk) disable iff (rst)
      inValid |=> (outFlags[gLane] ==
        (($past(inData[gLane*LANE_BITS +: LANE_BITS+1]) == '0) ||
         ($past(inData[gLane*LANE_BITS +: LANE_BITS+1]) == '1)))); // R3
  end

endmodule

bind byte_run_detector byte_run_detector_chk #(
  .LANE_BITS  (LANE_BITS),
  .LANE_COUNT (LANE_COUNT)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inData   (inData),
  .outValid (outValid),
  .outFlags (outFlags)
);

// File: tb/byte_run_detector_tb_top.sv
`timescale 1ns/1ps
module byte_run_detector_tb_top;

  localparam int LB = 8;
  localparam int LC = 8;
  localparam int WB = LB * LC + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic [WB-1:0] inData = '0;
  logic          outValid;
  logic [LC-1:0] outFlags;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  byte_run_detector dut_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outFlags (outFlags)
  );

  function automatic logic [LC-1:0] expectFlags(input logic [WB-1:0] w);
    logic [LC-1:0] e;
    for (int b = 0; b < LC; b++) begin
      logic [8:0] win;
      win = 9'((w >> (LB*b)) & 65'h1FF);
      e[b] = (win == 9'h000) || (win == 9'h1FF);
    end
    return e;
  endfunction

  task automatic check(input string req, input logic [LC-1:0] act,
                       input logic [LC-1:0] exp, input logic actV,
                       input logic expV);
    checks++;
    if (act !== exp || actV !== expV) begin
      errors++;
      $display("FAIL %s flags=%h valid=%b expected flags=%h valid=%b",
               req, act, actV, exp, expV);
    end
  endtask

  // Drive one word, then sample one cycle later away from the edge.
  task automatic sendWord(input logic [WB-1:0] w, input string req);
    inData  = w;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(req, outFlags, expectFlags(w), outValid, 1'b1);
  endtask

  function automatic logic [WB-1:0] randWord();
    logic [WB-1:0] r;
    r = {1'($urandom), 32'($urandom), 32'($urandom)};
    return r;
  endfunction

  initial begin
    logic [LC-1:0] held;
    logic [WB-1:0] bg;
    logic [WB-1:0] w;
    string tag;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", outFlags, '0, outValid, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R2", outFlags, '0, outValid, 1'b0);

    // R8: whole-word patterns
    sendWord('0, "R8");
    sendWord('1, "R8");
    sendWord({1'b0, {32{2'b01}}}, "R8");
    sendWord({1'b1, {32{2'b10}}}, "R8");

    // R7: run of nine ones starting at bit 4, rest zero
    w = '0;
    w[12:4] = '1;
    sendWord(w, "R7");
    checks++;
    if (outFlags[1:0] !== 2'b00) begin
      errors++;
      $display("FAIL R7 lanes1:0=%b expected 00", outFlags[1:0]);
    end

    // R9/R2: hold flags while idle with changing data
    sendWord('0, "R9");
    held = outFlags;
    for (int i = 0; i < 4; i++) begin
      inData = randWord();
      @(posedge clk);
      @(negedge clk);
      check("R9", outFlags, held, outValid, 1'b0);
    end

    // R3..R6: every nine-bit window pattern in every lane
    for (int b = 0; b < LC; b++) begin
      for (int p = 0; p < 512; p++) begin
        bg = randWord();
        w = (bg & ~(65'h1FF << (LB*b))) | (WB'(p) << (LB*b));
        if (b == LC-1)                  tag = "R6";
        else if (p == 0)                tag = "R3";
        else if (p == 'h1FF)            tag = "R4";
        else if (p == 'hFF || p == 'h100) tag = "R5";
        else                            tag = "R7";
        sendWord(w, tag);
      end
    end

    // R1: reset wins over a valid word on the same edge
    inData  = '0;
    inValid = 1'b1;
    rst     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", outFlags, '0, outValid, 1'b0);
    rst     = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule